// File: doc/BRIEF.md
# Programmable 32-bit Interval Timer

This block is a timer peripheral on a 16-bit register bus. Its core is a 32-bit up-counter driven by a programmable clock divider. Software sets a 32-bit limit as two 16-bit halves and a divide value. It then starts the counter in one of two ways. The first is a repeating mode, in which the count returns to zero after reaching the limit and keeps running. The second is a single-run mode, in which the count stops at the limit and the start bit clears itself.

On reaching the limit the block raises an internal event flag. The flag drives a level-high interrupt line when the interrupt enable bit is set. Any write to the control register clears the flag. The live count can be read as two 16-bit halves. A read of the lower half takes a snapshot of the upper half, so a lower-then-upper read pair always returns one consistent 32-bit value.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the limit reads 0xFFFF_FFFF, the divide register reads 0, the count reads 0 and `irq` is low.
- R2: Register byte offsets on `addr`: 0x00 control, 0x08 limit bits 15:0, 0x0C limit bits 31:16, 0x10 count bits 15:0, 0x14 count bits 31:16, 0x18 divide value. Control bit 0 = repeating run, bit 1 = single run, bit 8 = interrupt enable, other bits read 0. The limit and divide registers read back what was written. Reading an unmapped offset returns 0.
- R3: Any write to the control register clears the count to 0, restarts the divider and clears the event flag. Writing 0x0000 leaves the count stopped at 0 and `irq` low.
- R4: While control bit 0 or bit 1 is set, the count increases by exactly one on every divider tick and never decreases.
- R5: In repeating mode (bit 0 set), a tick that finds the count equal to the limit sets the count to 0 and sets the event flag, and counting carries on. With divide value p and limit L, the flag is set (L+1)·(p+1) clocks after the control write.
- R6: In single-run mode (bit 1 set, bit 0 clear), a tick that finds the count equal to the limit sets the event flag, clears bit 1 and leaves the count holding at the limit. When bit 0 and bit 1 are both set, repeating mode applies.
- R7: With divide value p, a divider tick occurs every p+1 clocks. The first tick comes p+1 clocks after a control write.
- R8: `irq` is high exactly while the event flag is set and control bit 8 is set. It stays high until a control write clears the flag.
- R9: A read returns its data on `rdata` in the clock after `rd_en`, and `rdata` is 0 otherwise. A read of the count lower half captures the count upper half at the same instant, and reads of the upper-half offset return that captured value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the clock after `rd_en` |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest case to reach from the ports is a torn split read. For that, the lower half must be sampled just before it rolls over into the upper half, and the upper half must be read after the rollover. To get there, the bench programs a limit above 0x1_0000 and starts the repeating mode with no division. It then counts clock edges from the control write so that the lower-half read lands on a count of 0xFFFE. A few clocks later it reads the upper half, which must still show the snapshot value 0 while the live upper half is already 1. A second read pair taken after the rollover must then return the new upper half.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BUS_W  = 16;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LIM_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_LIM_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_DIV    = 8'h18;

    typedef struct packed {
        logic irq_on;
        logic single;
        logic repeating;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_LIM_LO, SEL_LIM_HI, SEL_CNT_LO, SEL_CNT_HI, SEL_DIV
    } sel_e;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CTRL:   return SEL_CTRL;
            OFF_LIM_LO: return SEL_LIM_LO;
            OFF_LIM_HI: return SEL_LIM_HI;
            OFF_CNT_LO: return SEL_CNT_LO;
            OFF_CNT_HI: return SEL_CNT_HI;
            OFF_DIV:    return SEL_DIV;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w    = '0;
        w[0] = c.repeating;
        w[1] = c.single;
        w[8] = c.irq_on;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.repeating = w[0];
        c.single    = w[1];
        c.irq_on    = w[8];
        return c;
    endfunction
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          restart_i,
    input  logic [DW-1:0] ratio_m1_i,
    output logic          tick_o
);
    logic [DW-1:0] phase_q;

    assign tick_o = run_i && (phase_q == ratio_m1_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i || tick_o) phase_q <= '0;
        else                                       phase_q <= phase_q + 1'b1;
    end

    // R7: with a ratio above one, two ticks are never adjacent
    assert_tick_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !restart_i && ratio_m1_i != '0 && $stable(ratio_m1_i)) |=> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          repeating_i,
    input  logic          single_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] count_o,
    output logic          hit_o
);
    logic          run;
    logic          at_lim;
    logic [CW-1:0] count_q;

    assign run     = repeating_i || single_i;
    assign at_lim  = (count_q == limit_i);
    assign hit_o   = run && tick_i && at_lim && !start_i;
    assign count_o = count_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            count_q <= '0;
        end else if (run && tick_i) begin
            if (!at_lim)          count_q <= count_q + 1'b1;
            else if (repeating_i) count_q <= '0;
        end
    end

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && tick_i && !start_i && !at_lim) |=> (count_q == $past(count_q) + CW'(1)));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (repeating_i && tick_i && !start_i && at_lim) |=> (count_q == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !start_i) |=> $stable(count_q));
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_i,
    input  sel_e             sel_i,
    input  logic [BUS_W-1:0] ctrl_word_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [BUS_W-1:0] rdata_o
);
    logic [BUS_W-1:0] snap_q;
    logic [BUS_W-1:0] pick;

    always_comb begin
        case (sel_i)
            SEL_CTRL:   pick = ctrl_word_i;
            SEL_LIM_LO: pick = limit_i[BUS_W-1:0];
            SEL_LIM_HI: pick = limit_i[CNT_W-1:BUS_W];
            SEL_CNT_LO: pick = count_i[BUS_W-1:0];
            SEL_CNT_HI: pick = snap_q;
            SEL_DIV:    pick = ratio_i;
            default:    pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            rdata_o <= '0;
        end else begin
            rdata_o <= rd_en_i ? pick : '0;
            if (rd_en_i && sel_i == SEL_CNT_LO) snap_q <= count_i[CNT_W-1:BUS_W];
        end
    end

    // R9: the snapshot only moves on a lower-half read
    assert_snap_R9: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && sel_i == SEL_CNT_LO) |=> $stable(snap_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);
    sel_e             sel;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q;
    logic [DIV_W-1:0] ratio_q;
    logic             event_q;
    logic             ctrl_wr;
    logic             tick;
    logic             hit;
    logic [CNT_W-1:0] count;

    assign sel     = decode(addr);
    assign ctrl_wr = wr_en && (sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            limit_q <= '1;
            ratio_q <= '0;
            event_q <= 1'b0;
        end else begin
            if (ctrl_wr)                                   ctrl_q <= word_to_ctrl(wdata);
            else if (hit && ctrl_q.single && !ctrl_q.repeating) ctrl_q.single <= 1'b0;
            if (wr_en && sel == SEL_LIM_LO) limit_q[BUS_W-1:0]     <= wdata;
            if (wr_en && sel == SEL_LIM_HI) limit_q[CNT_W-1:BUS_W] <= wdata;
            if (wr_en && sel == SEL_DIV)    ratio_q                <= wdata[DIV_W-1:0];
            if (ctrl_wr)  event_q <= 1'b0;
            else if (hit) event_q <= 1'b1;
        end
    end

    assign irq = event_q && ctrl_q.irq_on;

    tmr_divider #(.DW(DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .run_i      (ctrl_q.repeating || ctrl_q.single),
        .restart_i  (ctrl_wr),
        .ratio_m1_i (ratio_q),
        .tick_o     (tick)
    );

    tmr_counter #(.CW(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .start_i     (ctrl_wr),
        .repeating_i (ctrl_q.repeating),
        .single_i    (ctrl_q.single),
        .tick_i      (tick),
        .limit_i     (limit_q),
        .count_o     (count),
        .hit_o       (hit)
    );

    tmr_readback u_rb (
        .clk         (clk),
        .rst         (rst),
        .rd_en_i     (rd_en),
        .sel_i       (sel),
        .ctrl_word_i (ctrl_to_word(ctrl_q)),
        .limit_i     (limit_q),
        .ratio_i     (ratio_q),
        .count_i     (count),
        .rdata_o     (rdata)
    );

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !irq);

    assert_single_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && ctrl_q.single && !ctrl_q.repeating && !ctrl_wr) |=> (!ctrl_q.single && event_q));

    assert_level_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr) |=> irq);
endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(input int cap, output int n);
        n = 0;
        while (!irq && n < cap) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 irq", irq, 0);
        rd(8'h00, d); chk("R1 ctrl", d, 16'h0000);
        rd(8'h08, d); chk("R1 limit lo", d, 16'hFFFF);
        rd(8'h0C, d); chk("R1 limit hi", d, 16'hFFFF);
        rd(8'h18, d); chk("R1 divide", d, 16'h0000);
        rd(8'h10, d); chk("R1 count lo", d, 16'h0000);
        rd(8'h14, d); chk("R1 count hi", d, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(8'h08, 16'h1234); wr(8'h0C, 16'hABCD); wr(8'h18, 16'h0005);
        rd(8'h08, d); chk("R2 limit lo readback", d, 16'h1234);
        rd(8'h0C, d); chk("R2 limit hi readback", d, 16'hABCD);
        rd(8'h18, d); chk("R2 divide readback", d, 16'h0005);
        rd(8'h04, d); chk("R2 unmapped", d, 16'h0000);
        idle(1);      chk("R9 rdata idle zero", rdata, 0);
        wr(8'h18, 16'h0000);
    endtask

    task automatic t_periodic();
        logic [15:0] d;
        int n;
        wr(8'h08, 16'd3); wr(8'h0C, 16'd0);
        wr(8'h00, 16'h0101);
        wait_irq(100, n);      chk("R5 wrap cycle", n, 4);
        rd(8'h10, d);          chk("R5 count back to zero", d, 0);
        rd(8'h10, d);          chk("R4 count keeps going", d, 1);
        chk("R8 irq level held", irq, 1);
        wr(8'h00, 16'h0101);   chk("R3 ctrl write clears irq", irq, 0);
        wr(8'h00, 16'h0000);
        idle(6);
        rd(8'h10, d);          chk("R3 stopped at zero", d, 0);
        chk("R3 irq low when stopped", irq, 0);
    endtask

    task automatic t_single();
        logic [15:0] d;
        int n;
        wr(8'h08, 16'd5);
        wr(8'h00, 16'h0102);
        wait_irq(100, n);      chk("R6 single-run flag cycle", n, 6);
        idle(10);
        rd(8'h10, d);          chk("R6 count holds at limit", d, 5);
        rd(8'h00, d);          chk("R6 start bit self-clears", d, 16'h0100);
        chk("R8 irq stays high", irq, 1);
        wr(8'h00, 16'h0000);   chk("R3 zero write clears irq", irq, 0);
    endtask

    task automatic t_divide();
        int n;
        wr(8'h08, 16'd2); wr(8'h18, 16'd8);
        wr(8'h00, 16'h0101);
        wait_irq(200, n);      chk("R7 divide by 9", n, 27);
        wr(8'h18, 16'd2);
        wr(8'h00, 16'h0101);
        wait_irq(200, n);      chk("R7 divide by 3", n, 9);
        wr(8'h00, 16'h0000);
        wr(8'h18, 16'd0);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        wr(8'h08, 16'd3);
        wr(8'h00, 16'h0002);
        idle(10);
        chk("R8 masked irq low", irq, 0);
        rd(8'h00, d);          chk("R6 masked run finished", d, 0);
        rd(8'h10, d);          chk("R6 masked count at limit", d, 3);
    endtask

    task automatic t_split();
        logic [15:0] d;
        wr(8'h08, 16'h0000); wr(8'h0C, 16'h0002);
        wr(8'h00, 16'h0001);
        idle(16'hFFFE);
        rd(8'h10, d);          chk("R9 low half", d, 16'hFFFE);
        idle(4);
        rd(8'h14, d);          chk("R9 upper from snapshot", d, 16'h0000);
        rd(8'h10, d);          chk("R9 low after rollover", d, 16'h0004);
        rd(8'h14, d);          chk("R9 upper after rollover", d, 16'h0001);
        wr(8'h00, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_periodic();
        t_single();
        t_divide();
        t_mask();
        t_split();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule